// File: doc/BRIEF.md
# Software Watchdog with Power-Fail Warning

This block watches over running software. A small time-out counter advances on a slow tick that a built-in prescaler derives from the system clock. Software has to restart it often enough. If a full period of 16 ticks passes with no restart, the counter wraps. It then raises a one-cycle interrupt request and latches a failure flag. The flag stays set until software clears it with a separate strobe. The default tick period is the time-out divided by 16. With a 50 MHz clock this gives a 125 ms window.

The same interrupt line carries an early warning of power loss. When the power-down notice input goes high, a clock counter starts. Once it has run the hold-up time minus the lead time, the block pulses the interrupt. That pulse therefore arrives the lead time (1 ms by default) before the supply drops, so software can save its state. Both event sources merge into one registered pulse output.

Top module: `sw_watchdog`

## Requirements
- R1: While reset is held and on the first cycle after reset, `irq_o` and `fail_o` are 0.
- R2: Without a restart, the counter wraps exactly CNT_LEN*TICK_DIV clock edges after the last restart edge (or after reset), where CNT_LEN is 2**CNT_W (16 by default). `irq_o` is then high for exactly one cycle, following that edge.
- R3: A wrap sets `fail_o` on the same edge that raises the `irq_o` pulse.
- R4: A restart strobe `kick_i` sampled high clears both the prescaler and the counter. A restart on the very edge that would have wrapped suppresses that wrap and its pulse.
- R5: `kick_i` leaves `fail_o` unchanged.
- R6: `fail_clr_i` sampled high clears `fail_o` on that edge. If a wrap happens on the same edge, the set wins.
- R7: With no restart, wraps repeat every CNT_LEN*TICK_DIV edges, and each one gives a fresh one-cycle pulse.
- R8: While `pwr_down_i` stays high, exactly one `irq_o` pulse follows the PF_DELAY-th consecutive edge that samples it high. PF_DELAY = PF_HOLDUP_CLKS - PF_LEAD_CLKS.
- R9: If `pwr_down_i` falls before PF_DELAY high edges, no pulse occurs, and a new rise restarts the count. The notice never changes `fail_o`.
- R10: A wrap and a power-fail event on the same edge produce a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Software restart strobe |
| fail_clr_i | input | 1 | Explicit clear of the failure flag |
| pwr_down_i | input | 1 | Power-down notice, level |
| irq_o | output | 1 | Priority interrupt request, one-cycle pulse per event |
| fail_o | output | 1 | Latched software-failure flag |

## Verification
The hardest cases to reach from the ports are those where two things land on the same clock edge. One is a restart on the exact edge of a wrap. Another is a flag clear on that edge. A third is a power-fail event on that edge. The bench counts idle cycles from a known restart edge and places the restart on edge CNT_LEN*TICK_DIV. It holds the clear strobe across a wrap. It raises the power notice PF_DELAY-1 edges before a wrap, so both events fire together. A per-cycle reference model judges every one of these cases, as well as a long pseudo-random stretch.

// File: rtl/sw_watchdog_pkg.sv
package sw_watchdog_pkg;

    // default width of the time-out counter
    localparam int unsigned WD_CNT_W_DEF = 4;

    // registered outputs of the top level
    typedef struct packed {
        logic irq;
        logic fail;
    } wd_out_t;

endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
    parameter int unsigned TICK_DIV = 390625
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    tick_w;

    always_comb begin
        st_d   = st_q;
        tick_w = !restart_i && (st_q.cnt == LAST);
        if (restart_i || tick_w) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = tick_w;

    // R4: a restart brings the prescaler back to zero
    assert_pre_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (st_q.cnt == '0));

    // R2: the prescaler never passes its last value
    assert_pre_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LAST);

endmodule

// File: rtl/wd_timeout_ctr.sv
module wd_timeout_ctr #(
    parameter int unsigned CNT_W = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic tick_i,
    output logic ovf_o
);
    localparam logic [CNT_W-1:0] TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } to_st_t;

    to_st_t st_d, st_q;
    logic   ovf_w;

    always_comb begin
        st_d  = st_q;
        ovf_w = 1'b0;
        if (restart_i) begin
            st_d.val = '0;
        end else if (tick_i) begin
            ovf_w    = (st_q.val == TOP);
            st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ovf_o = ovf_w;

    // R4: a restart zeroes the count
    assert_ctr_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (st_q.val == '0));

    // R7: wraps are never back to back
    assert_ovf_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_w |=> !ovf_w);

    // R2: the count holds between ticks
    assert_ctr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart_i && !tick_i) |=> $stable(st_q.val));

endmodule

// File: rtl/wd_pfail_timer.sv
module wd_pfail_timer #(
    parameter int unsigned DELAY = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic notice_i,
    output logic evt_o
);
    localparam int unsigned DW = $clog2(DELAY + 1);
    localparam logic [DW-1:0] LAST = DW'(DELAY - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          done;
    } pf_st_t;

    pf_st_t st_d, st_q;
    logic   evt_w;

    always_comb begin
        st_d  = st_q;
        evt_w = 1'b0;
        if (!notice_i) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (st_q.cnt == LAST) begin
                evt_w     = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign evt_o = evt_w;

    // R8: one warning per continuous notice
    assert_pf_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_w |=> !evt_w);

    // R9: a dropped notice rearms the timer
    assert_pf_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !notice_i |=> (st_q.cnt == '0 && !st_q.done));

endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog
    import sw_watchdog_pkg::*;
#(
    parameter int unsigned TICK_DIV       = 390625,
    parameter int unsigned CNT_W          = WD_CNT_W_DEF,
    parameter int unsigned PF_HOLDUP_CLKS = 250000,
    parameter int unsigned PF_LEAD_CLKS   = 50000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    input  logic fail_clr_i,
    input  logic pwr_down_i,
    output logic irq_o,
    output logic fail_o
);
    localparam int unsigned PF_DELAY =
        (PF_HOLDUP_CLKS > PF_LEAD_CLKS) ? (PF_HOLDUP_CLKS - PF_LEAD_CLKS) : 1;

    logic    tick_w;
    logic    ovf_w;
    logic    pf_evt_w;
    wd_out_t st_d, st_q;

    wd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (kick_i),
        .tick_o    (tick_w)
    );

    wd_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (kick_i),
        .tick_i    (tick_w),
        .ovf_o     (ovf_w)
    );

    wd_pfail_timer #(.DELAY(PF_DELAY)) u_pf (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .notice_i (pwr_down_i),
        .evt_o    (pf_evt_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = ovf_w | pf_evt_w;
        if (ovf_w) begin
            st_d.fail = 1'b1;
        end else if (fail_clr_i) begin
            st_d.fail = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o  = st_q.irq;
    assign fail_o = st_q.fail;

    // R3: the flag only rises after a wrap
    assert_fail_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.fail && !$past(st_q.fail)) |-> $past(ovf_w));

    // R3: a wrap raises both the pulse and the flag
    assert_ovf_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_w |=> (st_q.irq && st_q.fail));

    // R5: a restart does not drop the flag
    assert_kick_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.fail && kick_i && !fail_clr_i) |=> st_q.fail);

    // R6: the clear works when no wrap competes
    assert_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fail_clr_i && !ovf_w) |=> !st_q.fail);

    // R8: the power warning reaches the output
    assert_pf_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pf_evt_w |=> st_q.irq);

endmodule

// File: tb/sw_watchdog_tb_top.sv
module sw_watchdog_tb_top;
    localparam int unsigned DIV    = 3;
    localparam int unsigned HOLD   = 20;
    localparam int unsigned LEAD   = 8;
    localparam int unsigned DLY    = HOLD - LEAD;
    localparam int unsigned PERIOD = 16 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0, clr = 1'b0, pwr = 1'b0;
    logic irq, fail;

    int checks = 0;
    int bad    = 0;

    // reference model state
    int m_pre = 0, m_val = 0, m_pfc = 0;
    bit m_fail = 0, m_irq = 0, m_pfd = 0;

    always #10 clk = ~clk;

    sw_watchdog #(
        .TICK_DIV(DIV), .CNT_W(4),
        .PF_HOLDUP_CLKS(HOLD), .PF_LEAD_CLKS(LEAD)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .fail_clr_i(clr),
        .pwr_down_i(pwr), .irq_o(irq), .fail_o(fail)
    );

    task automatic compare(input string tag);
        checks += 2;
        if (irq !== m_irq) begin
            bad++;
            $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t", tag, irq, m_irq, $time);
        end
        if (fail !== m_fail) begin
            bad++;
            $display("FAIL %s fail_o actual=%0b expected=%0b t=%0t", tag, fail, m_fail, $time);
        end
    endtask

    // model advance for one edge with the inputs being driven
    task automatic model_edge(input bit k, input bit c, input bit p);
        bit ovf = 0;
        bit pfe = 0;
        bit tk;
        if (k) begin
            m_pre = 0;
            m_val = 0;
        end else begin
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) begin
                ovf   = (m_val == 15);
                m_val = (m_val + 1) % 16;
            end
        end
        if (!p) begin
            m_pfc = 0;
            m_pfd = 0;
        end else if (!m_pfd) begin
            if (m_pfc == DLY - 1) begin
                pfe   = 1;
                m_pfd = 1;
            end else begin
                m_pfc++;
            end
        end
        m_irq = ovf | pfe;
        if (ovf)    m_fail = 1;
        else if (c) m_fail = 0;
    endtask

    task automatic step(input bit k, input bit c, input bit p, input string tag);
        kick = k; clr = c; pwr = p;
        model_edge(k, c, p);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input bit p, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, p, tag);
    endtask

    initial begin
        int seed = 32'h1ace5eed;
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        step(0, 0, 0, "R1 first cycle");
        // free run: first wrap and repeats
        idle(PERIOD + 5, 0, "R2 R3 first wrap");
        idle(2 * PERIOD, 0, "R7 repeated wraps");
        // regular restarts keep it quiet, flag kept
        for (int j = 0; j < 6; j++) begin
            step(1, 0, 0, "R4 R5 restart");
            idle(PERIOD - 10, 0, "R4 R5 quiet");
        end
        step(0, 1, 0, "R6 clear");
        // restart on the exact wrap edge
        step(1, 0, 0, "R4 restart ref");
        idle(PERIOD - 1, 0, "R4 pre-coincide");
        step(1, 0, 0, "R4 restart on wrap edge");
        idle(5, 0, "R4 suppressed");
        // clear held across a wrap: set wins
        for (int j = 0; j < PERIOD + 3; j++) step(0, 1, 0, "R6 set beats clear");
        step(0, 1, 0, "R6 clear after");
        // power warning
        step(1, 0, 0, "R8 restart");
        idle(DLY + 10, 1, "R8 power warning");
        idle(3, 0, "R9 notice low");
        idle(DLY - 2, 1, "R9 short notice");
        idle(2, 0, "R9 drop");
        idle(DLY + 3, 1, "R9 rearmed");
        idle(2, 0, "R9 drop again");
        // power event coinciding with a wrap
        step(1, 0, 0, "R10 restart");
        idle(PERIOD - DLY, 0, "R10 wait");
        idle(DLY + 4, 1, "R10 merged pulse");
        idle(2, 0, "R10 release");
        // pseudo-random stretch
        for (int j = 0; j < 3000; j++) begin
            bit k, c, p;
            seed = seed ^ (seed << 13);
            seed = seed ^ (seed >> 17);
            seed = seed ^ (seed << 5);
            k = ((seed & 32'h3f) == 0);
            c = (((seed >> 8) & 32'h1f) == 0);
            p = (((seed >> 16) & 32'h3f) == 0) ? ~pwr : pwr;
            step(k, c, p, "R2 R4 R6 R8 random");
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule